// File: doc/BRIEF.md
# Multi-Mode Inversion Link Encoder

This block sits on the transmit side of a network-on-chip interface, between the stage that converts payload to Gray code and the wires of an inter-router link. For every accepted payload word it considers four ways of putting the word on the wires: unchanged, with the odd-indexed bits flipped, with the even-indexed bits flipped, or with every bit flipped. It scores each of the four against the word the link currently carries, using a weighted count of coupling transitions over neighbouring wire pairs. It then drives the cheapest one, together with a 2-bit code that tells the far end which flip to undo.

Each adjacent wire pair is classified by how its two lines change. If exactly one line toggles, the pair costs 1. If both toggle in opposite directions, it costs 2. If both toggle together, or neither toggles, it costs nothing. One detector bank and a pair of population counters serve each candidate, so all four scores are ready in the same cycle. A comparator stage picks the winner, and the chosen word is registered and becomes the reference for the next word.

Top module: `lnk_inv_encoder`

## Requirements
- R1: While reset is asserted, and in the first word after it, the held link word is all zeros and `enc_code` is 2'b00. A word presented right after reset is scored against an all-zero reference.
- R2: In a cycle where `in_valid` is low, `enc_data` and `enc_code` keep their values at the next clock edge, whatever `gray_in` carries.
- R3: Code 2'b10 means `enc_data` equals the input word with every bit at an odd index (1, 3, 5, ...) inverted.
- R4: Code 2'b01 means `enc_data` equals the input word with every bit at an even index (0, 2, 4, ...) inverted.
- R5: Code 2'b11 means `enc_data` equals the bitwise complement of the input word.
- R6: Code 2'b00 means `enc_data` equals the input word unchanged.
- R7: The cost of a candidate is computed against the current `enc_data`, summed over bit pairs (i, i+1). A pair where exactly one bit changes adds 1. A pair where both bits change and the new bits differ from each other adds 2. All other pairs add 0.
- R8: The action whose candidate has the lowest cost is applied.
- R9: When costs tie, the winner follows the priority none, then odd, then even, then full.
- R10: The reference for scoring the next word is the encoded word that was actually driven, not the raw input word.
- R11: A word accepted at a clock edge appears on `enc_data` and `enc_code` right after that same edge, with one register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Accept `gray_in` at this clock edge |
| gray_in | input | DW | Gray-coded payload word |
| enc_data | output | DW | Encoded word driven onto the link |
| enc_code | output | 2 | Inversion applied: 00 none, 10 odd, 01 even, 11 full |

## Verification
The bench builds the encoder at its default width of 8 bits, which gives seven neighbouring pairs. At this width, alternating patterns such as 0x55 and 0xAA make the odd and even flips collapse a word to a constant. A complemented word that follows a single-boundary word makes the full flip the only zero-cost choice. Hand-picked sequences then reach each of the four actions, ties between none and full and between odd and even, and a case where the stored encoded word, not the raw input, decides the outcome.

// File: rtl/lnk_inv_pkg.sv
package lnk_inv_pkg;

  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_EVEN = 2'b01,
    ACT_ODD  = 2'b10,
    ACT_FULL = 2'b11
  } act_e;

  // Candidate slots, in tie-break priority order.
  localparam int NUM_CAND = 4;
  localparam int SLOT_NONE = 0;
  localparam int SLOT_ODD  = 1;
  localparam int SLOT_EVEN = 2;
  localparam int SLOT_FULL = 3;

endpackage

// File: rtl/lnk_pair_classify.sv
module lnk_pair_classify #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] ref_word,
  input  logic [DW-1:0] cand_word,
  output logic [DW-2:0] single_flag,
  output logic [DW-2:0] opposite_flag
);
  logic [DW-1:0] toggled;

  assign toggled = ref_word ^ cand_word;

  for (genvar p = 0; p < DW - 1; p++) begin : g_pair
    // One line of the pair moves, the other holds.
    assign single_flag[p]   = toggled[p] ^ toggled[p+1];
    // Both move and end up at different levels: they moved in opposite directions.
    assign opposite_flag[p] = toggled[p] & toggled[p+1] & (cand_word[p] ^ cand_word[p+1]);
  end
endmodule

// File: rtl/lnk_ones_count.sv
module lnk_ones_count #(
  parameter int N  = 7,
  parameter int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  bits_in,
  output logic [CW-1:0] count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < N; i++) begin
      count = count + CW'(bits_in[i]);
    end
  end
endmodule

// File: rtl/lnk_pick.sv
module lnk_pick #(
  parameter int NC  = 4,
  parameter int CSW = 4,
  localparam int IW = $clog2(NC)
) (
  input  logic [CSW-1:0] cost [NC],
  output logic [IW-1:0]  win_idx,
  output logic [CSW-1:0] win_cost
);
  always_comb begin
    win_idx  = '0;
    win_cost = cost[0];
    // Strict comparison keeps the earlier slot on a tie.
    for (int k = 1; k < NC; k++) begin
      if (cost[k] < win_cost) begin
        win_idx  = IW'(k);
        win_cost = cost[k];
      end
    end
  end
endmodule

// File: rtl/lnk_inv_encoder.sv
module lnk_inv_encoder
  import lnk_inv_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] gray_in,
  output logic [DW-1:0] enc_data,
  output logic [1:0]    enc_code
);
  localparam int NPAIR = DW - 1;
  localparam int CNTW  = $clog2(NPAIR + 1);
  localparam int CSW   = CNTW + 1;
  localparam int IW    = $clog2(NUM_CAND);

  function automatic logic [DW-1:0] alt_mask(input logic odd_sel);
    logic [DW-1:0] m;
    for (int i = 0; i < DW; i++) m[i] = ((i % 2) == 1) == odd_sel;
    return m;
  endfunction

  localparam logic [DW-1:0] MASK_ODD  = alt_mask(1'b1);
  localparam logic [DW-1:0] MASK_EVEN = alt_mask(1'b0);

  // Reset: asserted at once, released through two flops.
  logic rst_s1, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_q  <= rst_s1;
    end
  end

  logic [DW-1:0]  cand      [NUM_CAND];
  logic [1:0]     cand_code [NUM_CAND];
  logic [CSW-1:0] cost      [NUM_CAND];

  assign cand[SLOT_NONE] = gray_in;
  assign cand[SLOT_ODD]  = gray_in ^ MASK_ODD;
  assign cand[SLOT_EVEN] = gray_in ^ MASK_EVEN;
  assign cand[SLOT_FULL] = ~gray_in;

  assign cand_code[SLOT_NONE] = ACT_NONE;
  assign cand_code[SLOT_ODD]  = ACT_ODD;
  assign cand_code[SLOT_EVEN] = ACT_EVEN;
  assign cand_code[SLOT_FULL] = ACT_FULL;

  for (genvar k = 0; k < NUM_CAND; k++) begin : g_cand
    logic [NPAIR-1:0] f_single, f_opp;
    logic [CNTW-1:0]  n_single, n_opp;

    lnk_pair_classify #(.DW(DW)) u_cls (
      .ref_word      (enc_data),
      .cand_word     (cand[k]),
      .single_flag   (f_single),
      .opposite_flag (f_opp)
    );

    lnk_ones_count #(.N(NPAIR), .CW(CNTW)) u_cnt_single (
      .bits_in (f_single),
      .count   (n_single)
    );

    lnk_ones_count #(.N(NPAIR), .CW(CNTW)) u_cnt_opp (
      .bits_in (f_opp),
      .count   (n_opp)
    );

    // Weight 1 for a lone toggle, weight 2 for an opposing pair.
    assign cost[k] = CSW'(n_single) + {n_opp, 1'b0};
  end

  logic [IW-1:0]  sel;
  logic [CSW-1:0] sel_cost;

  lnk_pick #(.NC(NUM_CAND), .CSW(CSW)) u_pick (
    .cost     (cost),
    .win_idx  (sel),
    .win_cost (sel_cost)
  );

  // Next-state and register processes.
  logic [DW-1:0] data_nxt;
  logic [1:0]    code_nxt;

  always_comb begin
    data_nxt = enc_data;
    code_nxt = enc_code;
    if (in_valid) begin
      data_nxt = cand[sel];
      code_nxt = cand_code[sel];
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      enc_data <= '0;
      enc_code <= ACT_NONE;
    end else if (in_valid) begin
      enc_data <= data_nxt;
      enc_code <= code_nxt;
    end
  end

  // R1
  always_ff @(posedge clk) begin
    if (!rst_q) begin
      reset_clear_chk: assert (enc_data == '0 && enc_code == 2'b00);
    end
  end

  // R2
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !in_valid |=> ($stable(enc_data) && $stable(enc_code)));

  // R3 R4 R5 R6 R11: the driven word is the input with the coded mask applied
  code_mask_chk: assert property (@(posedge clk) disable iff (!rst_q)
    in_valid |=> ((enc_data ^ $past(gray_in)) ==
                  ((enc_code == 2'b10) ? MASK_ODD  :
                   (enc_code == 2'b01) ? MASK_EVEN :
                   (enc_code == 2'b11) ? {DW{1'b1}} : {DW{1'b0}})));

  // R8
  for (genvar k = 0; k < NUM_CAND; k++) begin : g_min_chk
    min_cost_chk: assert property (@(posedge clk) disable iff (!rst_q)
      sel_cost <= cost[k]);
  end

  // R9
  tie_none_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (cost[SLOT_NONE] <= cost[SLOT_ODD] && cost[SLOT_NONE] <= cost[SLOT_EVEN] &&
     cost[SLOT_NONE] <= cost[SLOT_FULL]) |-> (sel == IW'(SLOT_NONE)));

endmodule

// File: tb/lnk_inv_encoder_tb_top.sv
`timescale 1ns/1ps
module lnk_inv_encoder_tb_top;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] gray_in = '0;
  logic [DW-1:0] enc_data;
  logic [1:0]    enc_code;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lnk_inv_encoder #(.DW(DW)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .gray_in  (gray_in),
    .enc_data (enc_data),
    .enc_code (enc_code)
  );

  // {input, expected data, expected code}, applied in order from reset.
  localparam logic [17:0] VEC [8] = '{
    {8'h00, 8'h00, 2'b00},  // R6 zero word, none
    {8'h55, 8'hFF, 2'b10},  // R3 R9 odd beats even on tie
    {8'hFF, 8'hFF, 2'b00},  // R10 reference is FF, not 55
    {8'hAA, 8'h00, 2'b10},  // R3 R7 odd
    {8'h0F, 8'h0F, 2'b00},  // R9 none ties with full at cost 1
    {8'hF0, 8'h0F, 2'b11},  // R5 R7 full removes opposing pair
    {8'h5A, 8'h0F, 2'b01},  // R4 R8 even, odd costs 2
    {8'h00, 8'h00, 2'b00}   // R6 R8 none at cost 1
  };

  task automatic check(input string req, input logic [DW-1:0] exp_d, input logic [1:0] exp_c);
    checks++;
    if (enc_data !== exp_d || enc_code !== exp_c) begin
      errors++;
      $display("FAIL %s: data=%h code=%b expected data=%h code=%b",
               req, enc_data, enc_code, exp_d, exp_c);
    end
  endtask

  task automatic step(input logic v, input logic [DW-1:0] w);
    @(negedge clk);
    in_valid = v;
    gray_in  = w;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1 during reset", 8'h00, 2'b00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after release", 8'h00, 2'b00);

    for (int i = 0; i < 8; i++) begin
      step(1'b1, VEC[i][17:10]);
      check($sformatf("R11 vector %0d", i), VEC[i][9:2], VEC[i][1:0]);
    end

    // R2: idle cycles with noisy input leave the link untouched
    step(1'b0, 8'hFF);
    check("R2 idle 1", 8'h00, 2'b00);
    step(1'b0, 8'h3C);
    check("R2 idle 2", 8'h00, 2'b00);

    // R3 R9: from 00, 5A gives odd F0 and even 0F both at cost 1
    step(1'b1, 8'h5A);
    check("R3 R9 odd over even", 8'hF0, 2'b10);

    // R1: reset in mid-run clears the reference
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R1 mid-run reset", 8'h00, 2'b00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    step(1'b1, 8'h55);
    check("R1 reference cleared", 8'hFF, 2'b10);

    // R5: complement of a single-boundary reference
    step(1'b1, 8'h00);
    check("R6 after FF", 8'h00, 2'b00);
    step(1'b1, 8'h0F);
    check("R6 setup", 8'h0F, 2'b00);
    step(1'b1, 8'hF0);
    check("R5 full", 8'h0F, 2'b11);
    step(1'b0, 8'h00);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule